// File: doc/BRIEF.md
# SMBus Clock-Stretch and Bus-Timeout Monitor

This block supervises the target side of a two-wire SMBus-style link. It does not shift bytes or match addresses. It watches the sampled clock and data lines, a busy request from the device logic, a strobe marking that the ninth (acknowledge) bit of a byte has completed, and a strobe marking a detected START condition. From these it decides when the target may hold SCL low to gain time.

A clock stretch may begin only in a window that the ninth-bit strobe or the START strobe opens. No stretch lasts longer than a bounded number of cycles: when that limit runs out, the pull-down is released even if the device is still busy. Apart from a stretch, the block never drives the clock.

A separate timer counts consecutive cycles in which both lines are seen low. When that count reaches the lock-up limit, the block issues a one-cycle abort strobe, raises a timeout flag, and lets go of SCL. It then ignores bus activity until the next START. Both limits are set in microseconds and turned into cycle counts from a clock-frequency parameter.

Top module: `smbus_stretch_monitor`

## Requirements
- R1: After synchronous reset, `scl_hold`, `abort_pulse` and `timeout_flag` are all 0.
- R2: A pulse on `ninth_done` or `start_det` opens a stretch window. While the window is open and `scl_in` is sampled low, a high `busy_req` starts a stretch. If `busy_req` is already high when the strobe arrives, `scl_hold` rises two cycles after the strobe cycle.
- R3: While no window is open, `busy_req` has no effect on `scl_hold`. A window closes without a stretch if `scl_in` is sampled high before `busy_req` rises. A window also closes when a stretch ends, so a still-asserted `busy_req` does not start a second stretch.
- R4: `scl_hold` falls in the first cycle after `busy_req` has been sampled low during a stretch.
- R5: A stretch holds `scl_hold` high for at most STRETCH_CYC consecutive cycles and then releases it, even while `busy_req` stays high.
- R6: After TIMEOUT_CYC consecutive samples with both `scl_in` and `sda_in` low, `abort_pulse` is high for exactly one cycle. That cycle is the one after the last of those samples.
- R7: The low-hold count restarts from zero whenever `scl_in` or `sda_in` is sampled high.
- R8: When `abort_pulse` rises, `timeout_flag` rises in the same cycle and `scl_hold` is 0 from that cycle on. While the flag is set, no further abort occurs and strobes on `ninth_done` do not start a stretch.
- R9: A `start_det` pulse clears `timeout_flag` in the following cycle. That same strobe opens a stretch window.
- R10: STRETCH_CYC = CLK_HZ * STRETCH_US / 1,000,000 and TIMEOUT_CYC = CLK_HZ * TIMEOUT_US / 1,000,000, with integer division. STRETCH_CYC must be smaller than TIMEOUT_CYC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Sampled clock line |
| sda_in | input | 1 | Sampled data line |
| busy_req | input | 1 | Device logic asks for more time |
| ninth_done | input | 1 | One-cycle strobe: ninth bit of a byte completed |
| start_det | input | 1 | One-cycle strobe: START condition detected |
| scl_hold | output | 1 | Enable for the SCL pull-down |
| abort_pulse | output | 1 | One-cycle strobe: transaction aborted on lock-up |
| timeout_flag | output | 1 | Set on abort, cleared by the next START |

## Verification
The bench builds the block with CLK_HZ = 2,000,000, STRETCH_US = 10 and TIMEOUT_US = 15. These values give a 20-cycle stretch limit and a 30-cycle lock-up limit. At these sizes a full stretch that runs out, a low-hold timeout, and a timeout restarted partway through can each be reached in a few dozen cycles. The default millisecond limits would need millions of cycles. The short limits also make it possible to fire a timeout in the middle of an active stretch and to observe the lockout and its release by START.

// File: rtl/smbmon_pkg.sv
package smbmon_pkg;

    // Stretch controller phases
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,   // no window open
        S_ARMED = 2'd1,   // window open, waiting for busy with SCL low
        S_HOLD  = 2'd2    // SCL pull-down active
    } stretch_state_t;

    // Convert a time in microseconds to a cycle count at the given clock rate.
    function automatic longint unsigned us_to_cycles(longint unsigned clk_hz,
                                                     longint unsigned usec);
        return (clk_hz * usec) / 64'd1_000_000;
    endfunction

endpackage

// File: rtl/smbmon_stretch_ctrl.sv
module smbmon_stretch_ctrl #(
    parameter int unsigned ST_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic busy_req,
    input  logic permit,     // window-opening strobe
    input  logic block,      // lockout or abort in progress
    output logic hold
);
    import smbmon_pkg::*;

    localparam int unsigned CW = $clog2(ST_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(ST_CYC - 1);

    stretch_state_t st;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (permit && !block) st <= S_ARMED;
                end
                S_ARMED: begin
                    if (block || scl_in) begin
                        st <= S_IDLE;          // lockout or window missed
                    end else if (busy_req) begin
                        st  <= S_HOLD;
                        cnt <= '0;
                    end
                end
                S_HOLD: begin
                    if (block || !busy_req || cnt == LAST) st <= S_IDLE;
                    else                                   cnt <= cnt + 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign hold = (st == S_HOLD);

endmodule

// File: rtl/smbmon_lowhold_timer.sv
module smbmon_lowhold_timer #(
    parameter int unsigned TO_CYC = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic suppress,   // held in lockout
    output logic fire        // combinational: limit reached this cycle
);
    localparam int unsigned CW = $clog2(TO_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TO_CYC - 1);
    localparam logic [CW-1:0] TOP  = CW'(TO_CYC);

    logic [CW-1:0] cnt;
    logic          both_low;

    assign both_low = !scl_in && !sda_in;

    always_ff @(posedge clk) begin
        if (rst || suppress || !both_low) cnt <= '0;
        else if (cnt != TOP)              cnt <= cnt + 1'b1;
    end

    assign fire = !suppress && both_low && (cnt == LAST);

endmodule

// File: rtl/smbus_stretch_monitor.sv
module smbus_stretch_monitor #(
    parameter longint unsigned CLK_HZ     = 50_000_000,
    parameter longint unsigned STRETCH_US = 25_000,
    parameter longint unsigned TIMEOUT_US = 35_000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic busy_req,
    input  logic ninth_done,
    input  logic start_det,
    output logic scl_hold,
    output logic abort_pulse,
    output logic timeout_flag
);
    localparam int unsigned STRETCH_CYC =
        int'(smbmon_pkg::us_to_cycles(CLK_HZ, STRETCH_US));
    localparam int unsigned TIMEOUT_CYC =
        int'(smbmon_pkg::us_to_cycles(CLK_HZ, TIMEOUT_US));

    logic fire;
    logic lock_q;
    logic abort_q;
    logic block;
    logic permit;

    assign permit = ninth_done || start_det;
    // A START ends the lockout and may open a window in the same cycle.
    assign block  = fire || (lock_q && !start_det);

    smbmon_stretch_ctrl #(.ST_CYC(STRETCH_CYC)) u_stretch (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_in),
        .busy_req (busy_req),
        .permit   (permit),
        .block    (block),
        .hold     (scl_hold)
    );

    smbmon_lowhold_timer #(.TO_CYC(TIMEOUT_CYC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .suppress (lock_q),
        .fire     (fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            abort_q <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            abort_q <= fire;
            if (fire)           lock_q <= 1'b1;
            else if (start_det) lock_q <= 1'b0;
        end
    end

    assign abort_pulse  = abort_q;
    assign timeout_flag = lock_q;

endmodule

// File: rtl/smbmon_checker.sv
module smbmon_checker #(
    parameter int unsigned ST_CYC = 20,
    parameter int unsigned TO_CYC = 30
) (
    input logic clk,
    input logic rst,
    input logic scl_in,
    input logic sda_in,
    input logic busy_req,
    input logic start_det,
    input logic scl_hold,
    input logic abort_pulse,
    input logic timeout_flag
);
    localparam int unsigned RW = $clog2(ST_CYC + 2);

    logic [RW-1:0] hold_run;   // consecutive hold cycles seen so far

    always_ff @(posedge clk) begin
        if (rst)                                hold_run <= '0;
        else if (!scl_hold)                     hold_run <= '0;
        else if (hold_run != RW'(ST_CYC + 1))   hold_run <= hold_run + 1'b1;
    end

    initial begin
        a_r10_stretch_below_timeout: assert (ST_CYC < TO_CYC);
    end

    a_r5_stretch_bounded: assert property (@(posedge clk) disable iff (rst)
        scl_hold |-> (hold_run < RW'(ST_CYC)));

    a_r2_stretch_needs_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_hold) |-> $past(busy_req));

    a_r6_abort_single_cycle: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |=> !abort_pulse);

    a_r6_abort_after_low: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> $past(!scl_in && !sda_in));

    a_r8_abort_sets_flag: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> timeout_flag);

    a_r8_locked_no_hold: assert property (@(posedge clk) disable iff (rst)
        timeout_flag |-> !scl_hold);

    a_r8_locked_no_abort: assert property (@(posedge clk) disable iff (rst)
        timeout_flag |=> !abort_pulse);

    a_r9_start_clears_flag: assert property (@(posedge clk) disable iff (rst)
        (start_det && timeout_flag) |=> !timeout_flag);

endmodule

bind smbus_stretch_monitor smbmon_checker #(
    .ST_CYC (STRETCH_CYC),
    .TO_CYC (TIMEOUT_CYC)
) u_smbmon_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_in       (scl_in),
    .sda_in       (sda_in),
    .busy_req     (busy_req),
    .start_det    (start_det),
    .scl_hold     (scl_hold),
    .abort_pulse  (abort_pulse),
    .timeout_flag (timeout_flag)
);

// File: tb/test_smbus_stretch_monitor.sv
module test_smbus_stretch_monitor;

    // 2 MHz * 10 us = 20 cycles, 2 MHz * 15 us = 30 cycles (R10)
    localparam int ST = 20;
    localparam int TO = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_drv = 1'b1;
    logic sda_in = 1'b1;
    logic busy_req = 1'b0;
    logic ninth_done = 1'b0;
    logic start_det = 1'b0;
    logic scl_in;
    logic scl_hold, abort_pulse, timeout_flag;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int    at;
        int    hold;    // -1 = don't care
        int    abrt;
        int    flag;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // wired-AND: the pull-down wins over the host's released clock
    assign scl_in = scl_drv & ~scl_hold;

    smbus_stretch_monitor #(
        .CLK_HZ     (2_000_000),
        .STRETCH_US (10),
        .TIMEOUT_US (15)
    ) i_smbus_stretch_monitor (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (scl_in),
        .sda_in       (sda_in),
        .busy_req     (busy_req),
        .ninth_done   (ninth_done),
        .start_det    (start_det),
        .scl_hold     (scl_hold),
        .abort_pulse  (abort_pulse),
        .timeout_flag (timeout_flag)
    );

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wait_until(int t);
        while (cyc < t) tick(1);
    endtask

    task automatic expect_at(int at, int h, int a, int f, string tag);
        exp_t e;
        e.at = at; e.hold = h; e.abrt = a; e.flag = f; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: pops scoreboard items when their cycle comes up
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.at != cyc) begin
                errors++;
                $display("FAIL %s: sample for cycle %0d missed (now %0d)", e.tag, e.at, cyc);
            end else if ((e.hold >= 0 && int'(scl_hold) != e.hold) ||
                         (e.abrt >= 0 && int'(abort_pulse) != e.abrt) ||
                         (e.flag >= 0 && int'(timeout_flag) != e.flag)) begin
                errors++;
                $display("FAIL %s @%0d: hold/abort/flag actual %0d/%0d/%0d expected %0d/%0d/%0d",
                         e.tag, cyc, scl_hold, abort_pulse, timeout_flag,
                         e.hold, e.abrt, e.flag);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c;
        tick(3);
        rst = 1'b0;
        c = cyc;
        expect_at(c + 1, 0, 0, 0, "R1 reset state");
        tick(3);

        // Stretch after ninth bit runs into the limit (R2, R5, R10, R3)
        c = cyc;
        scl_drv = 1'b0; busy_req = 1'b1; ninth_done = 1'b1;
        expect_at(c + 1,      0, 0, 0, "R2 not yet held");
        expect_at(c + 2,      1, 0, 0, "R2 hold two cycles after strobe");
        expect_at(c + 1 + ST, 1, 0, 0, "R5 R10 last held cycle");
        expect_at(c + 2 + ST, 0, 0, 0, "R5 released at limit while busy");
        expect_at(c + 6 + ST, 0, 0, 0, "R3 no second stretch");
        tick(1);
        ninth_done = 1'b0;
        wait_until(c + ST + 8);
        busy_req = 1'b0; scl_drv = 1'b1;
        tick(2);

        // Busy released early (R4)
        c = cyc;
        scl_drv = 1'b0; busy_req = 1'b1; ninth_done = 1'b1;
        expect_at(c + 2, 1, 0, 0, "R2 hold after ninth bit");
        expect_at(c + 6, 1, 0, 0, "R4 held while busy");
        expect_at(c + 7, 0, 0, 0, "R4 release after busy low");
        tick(1);
        ninth_done = 1'b0;
        wait_until(c + 6);
        busy_req = 1'b0;
        tick(1);
        scl_drv = 1'b1;
        tick(2);

        // Busy without window, then a missed window (R3)
        c = cyc;
        busy_req = 1'b1; scl_drv = 1'b0;
        expect_at(c + 3,  0, 0, 0, "R3 busy outside window");
        expect_at(c + 10, 0, 0, 0, "R3 busy outside window later");
        wait_until(c + 12);
        busy_req = 1'b0;
        c = cyc;
        ninth_done = 1'b1;
        expect_at(c + 6, 0, 0, 0, "R3 window closed by SCL high");
        expect_at(c + 8, 0, 0, 0, "R3 window stays closed");
        tick(1);
        ninth_done = 1'b0;
        wait_until(c + 2);
        scl_drv = 1'b1;
        wait_until(c + 4);
        scl_drv = 1'b0; busy_req = 1'b1;
        wait_until(c + 10);
        busy_req = 1'b0; scl_drv = 1'b1;
        tick(2);

        // Stretch at START (R9, R4)
        c = cyc;
        start_det = 1'b1; busy_req = 1'b1; scl_drv = 1'b0;
        expect_at(c + 2, 1, 0, 0, "R9 START opens window");
        expect_at(c + 4, 1, 0, 0, "R9 hold continues");
        expect_at(c + 5, 0, 0, 0, "R4 release after busy low");
        tick(1);
        start_det = 1'b0;
        wait_until(c + 4);
        busy_req = 1'b0;
        tick(1);
        scl_drv = 1'b1;
        tick(2);

        // Timeout with restart, then lockout (R7, R6, R8)
        c = cyc;
        scl_drv = 1'b0; sda_in = 1'b0; busy_req = 1'b0;
        expect_at(c + 30, 0, 0, 0, "R7 restart delays abort");
        expect_at(c + 50, 0, 0, 0, "R7 not yet");
        expect_at(c + 51, 0, 1, 1, "R6 R10 abort after limit");
        expect_at(c + 52, 0, 0, 1, "R6 abort lasts one cycle");
        expect_at(c + 56, 0, 0, 1, "R8 ninth-bit strobe ignored");
        expect_at(c + 90, 0, 0, 1, "R8 no second abort");
        wait_until(c + 20);
        sda_in = 1'b1;
        wait_until(c + 21);
        sda_in = 1'b0;
        wait_until(c + 53);
        ninth_done = 1'b1; busy_req = 1'b1;
        tick(1);
        ninth_done = 1'b0;
        wait_until(c + 92);

        // START ends lockout (R9)
        c = cyc;
        sda_in = 1'b1; scl_drv = 1'b1; busy_req = 1'b0;
        expect_at(c + 1, 0, 0, 1, "R8 flag held until START");
        expect_at(c + 2, 0, 0, 0, "R9 START clears flag");
        expect_at(c + 3, 0, 0, 0, "R9 flag stays clear");
        tick(1);
        start_det = 1'b1;
        tick(1);
        start_det = 1'b0;
        tick(3);

        // Timeout during an active stretch (R8)
        c = cyc;
        scl_drv = 1'b0; sda_in = 1'b0; busy_req = 1'b1;
        expect_at(c + 16, 1, 0, 0, "R2 stretch starts in window");
        expect_at(c + 29, 1, 0, 0, "R8 still held before abort");
        expect_at(c + 30, 0, 1, 1, "R8 abort releases SCL");
        wait_until(c + 14);
        ninth_done = 1'b1;
        tick(1);
        ninth_done = 1'b0;
        wait_until(c + 32);
        sda_in = 1'b1; scl_drv = 1'b1; busy_req = 1'b0;
        tick(1);
        start_det = 1'b1;
        tick(1);
        start_det = 1'b0;
        tick(3);

        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule